// File: doc/BRIEF.md
# Register-Immediate Integer Execute Stage

This block is the execute and write-back slice of a small 32-bit three-format RISC core. Each cycle it may accept one instruction word, qualified by a valid strobe. It decodes the word as either a register-register form or a register-immediate form. It reads two source operands from an internal bank of 32 general registers and computes an arithmetic, compare or logic result. On the next rising clock edge it writes that result to the destination register.

The supported operations are:
- add, subtract and signed set-on-less-than between two registers;
- add-immediate and signed set-on-less-than-immediate;
- and-immediate and or-immediate;
- load-upper-immediate.

Register 0 is a constant zero. If a valid word does not decode, the block raises a flag in the same cycle and changes nothing.

A debug address selects any register, and its contents appear on the debug data output without a clock. A testbench or a neighbouring pipeline stage uses this port to observe architectural state.

Top module: `risc_exec_unit`

## Requirements
- R1: While rst_ni is low, and after it is released with no write yet made, every register reads zero on the debug port.
- R2: Register form with opcode bits [31:26]=0 and function bits [5:0]=32 writes rs+rt into rd. The source fields are rs=[25:21] and rt=[20:16], and the destination is rd=[15:11]. The sum wraps modulo 2^32 and never traps.
- R3: Register form with function 34 writes rs-rt into rd, wrapping modulo 2^32.
- R4: Register form with function 42 writes 1 into rd when rs is less than rt as signed two's-complement values, and writes 0 otherwise.
- R5: Opcode 8 writes rs plus the sign-extended immediate [15:0] into rt=[20:16].
- R6: Opcode 10 writes 1 into rt when rs is less than the sign-extended immediate as signed values, and writes 0 otherwise.
- R7: Opcode 12 writes rs AND the zero-extended immediate into rt. Opcode 13 writes rs OR the zero-extended immediate into rt.
- R8: Opcode 15 writes the immediate into bits 31:16 of rt and zeros into bits 15:0. A following opcode 13 on the same register can then fill in the low half.
- R9: Register 0 always reads zero. Any write aimed at it is discarded.
- R10: A valid word with any other opcode, or with opcode 0 and any other function code, drives illegal_o high in the same cycle and writes no register. illegal_o is low whenever valid_i is low.
- R11: With valid_i low, no register changes, whatever instr_i holds.
- R12: dbg_data_o follows dbg_addr_i combinationally, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; write-back on rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all registers |
| instr_i | input | 32 | Instruction word |
| valid_i | input | 1 | Instruction word is valid this cycle |
| dbg_addr_i | input | 5 | Register index for the debug read |
| dbg_data_o | output | 32 | Contents of the selected register |
| illegal_o | output | 1 | Valid word has an unsupported opcode or function |

## Verification
Any internal fault here ends up as a wrong value in a register. It therefore shows on dbg_data_o one clock edge after the offending instruction, once the debug address points at the destination.

A decode slip has a different signature:
- a wrong destination field corrupts some other register, which stays silent until that register is read;
- a wrong extension choice shows up only for immediates with bit 15 set;
- a signed/unsigned compare mix-up shows up only when the operands differ in sign.

The vectors therefore read each destination right after its write, and they include operands chosen to exercise each of these cases. Decode faults on illegal words are visible on illegal_o within the same cycle, and as an unchanged register after the next edge.

// File: rtl/risc_ex_pkg.sv
package risc_ex_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREGS  = 1 << REG_AW;
  localparam int IMM_W  = 16;

  // Major opcodes and function codes
  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_LUI   = 6'd15;
  localparam logic [5:0] FN_ADD    = 6'd32;
  localparam logic [5:0] FN_SUB    = 6'd34;
  localparam logic [5:0] FN_SLT    = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e             op;
    logic                use_imm;
    logic [XLEN-1:0]     imm;
    logic [REG_AW-1:0]   dst;
    logic                wr;
    logic                illegal;
  } ex_ctrl_t;
endpackage

// File: rtl/ex_regfile.sv
module ex_regfile
  import risc_ex_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ra_addr_i,
  output logic [XLEN-1:0]   ra_data_o,
  input  logic [REG_AW-1:0] rb_addr_i,
  output logic [XLEN-1:0]   rb_data_o,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [XLEN-1:0]   rd_data_o,
  input  logic              we_i,
  input  logic [REG_AW-1:0] wa_i,
  input  logic [XLEN-1:0]   wd_i
);
  // Entry 0 is not stored
  logic [XLEN-1:0] regs_q [1:NREGS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  always_comb ra_data_o = (ra_addr_i == '0) ? '0 : regs_q[ra_addr_i];
  always_comb rb_data_o = (rb_addr_i == '0) ? '0 : regs_q[rb_addr_i];
  always_comb rd_data_o = (rd_addr_i == '0) ? '0 : regs_q[rd_addr_i];
endmodule

// File: rtl/ex_decode.sv
module ex_decode
  import risc_ex_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  input  logic            valid_i,
  output ex_ctrl_t        ctrl_o
);
  logic [5:0]        opc, fn;
  logic [REG_AW-1:0] rt, rd;
  logic [IMM_W-1:0]  imm16;
  logic [4:0]        unused_shamt;
  logic              bad;

  assign opc          = instr_i[31:26];
  assign rt           = instr_i[20:16];
  assign rd           = instr_i[15:11];
  assign unused_shamt = instr_i[10:6];
  assign fn           = instr_i[5:0];
  assign imm16        = instr_i[IMM_W-1:0];

  always_comb begin
    ctrl_o.op      = ALU_ADD;
    ctrl_o.use_imm = 1'b1;
    ctrl_o.imm     = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
    ctrl_o.dst     = rt;
    bad            = 1'b0;
    unique case (opc)
      OPC_RTYPE: begin
        ctrl_o.use_imm = 1'b0;
        ctrl_o.dst     = rd;
        unique case (fn)
          FN_ADD:  ctrl_o.op = ALU_ADD;
          FN_SUB:  ctrl_o.op = ALU_SUB;
          FN_SLT:  ctrl_o.op = ALU_SLT;
          default: bad = 1'b1;
        endcase
      end
      OPC_ADDI: ctrl_o.op = ALU_ADD;
      OPC_SLTI: ctrl_o.op = ALU_SLT;
      OPC_ANDI: begin
        ctrl_o.op  = ALU_AND;
        ctrl_o.imm = {{(XLEN-IMM_W){1'b0}}, imm16};
      end
      OPC_ORI: begin
        ctrl_o.op  = ALU_OR;
        ctrl_o.imm = {{(XLEN-IMM_W){1'b0}}, imm16};
      end
      OPC_LUI: begin
        ctrl_o.op  = ALU_LUI;
        ctrl_o.imm = {{(XLEN-IMM_W){1'b0}}, imm16};
      end
      default: bad = 1'b1;
    endcase
    ctrl_o.illegal = valid_i & bad;
    ctrl_o.wr      = valid_i & ~bad & (ctrl_o.dst != '0);
  end
endmodule

// File: rtl/ex_alu.sv
module ex_alu
  import risc_ex_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_LUI: y_o = {b_i[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/risc_exec_unit.sv
module risc_exec_unit
  import risc_ex_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   instr_i,
  input  logic              valid_i,
  input  logic [REG_AW-1:0] dbg_addr_i,
  output logic [XLEN-1:0]   dbg_data_o,
  output logic              illegal_o
);
  ex_ctrl_t          ctrl;
  logic [XLEN-1:0]   rs_data, rt_data, opb, result;
  logic              wr_en;
  logic [REG_AW-1:0] wr_addr;

  ex_decode u_dec (
    .instr_i (instr_i),
    .valid_i (valid_i),
    .ctrl_o  (ctrl)
  );

  assign opb     = ctrl.use_imm ? ctrl.imm : rt_data;
  assign wr_en   = ctrl.wr;
  assign wr_addr = ctrl.dst;

  ex_alu u_alu (
    .op_i (ctrl.op),
    .a_i  (rs_data),
    .b_i  (opb),
    .y_o  (result)
  );

  ex_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (instr_i[25:21]),
    .ra_data_o (rs_data),
    .rb_addr_i (instr_i[20:16]),
    .rb_data_o (rt_data),
    .rd_addr_i (dbg_addr_i),
    .rd_data_o (dbg_data_o),
    .we_i      (wr_en),
    .wa_i      (wr_addr),
    .wd_i      (result)
  );

  assign illegal_o = ctrl.illegal;
endmodule

// File: rtl/risc_exec_unit_chk.sv
module risc_exec_unit_chk
  import risc_ex_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [XLEN-1:0]   instr_i,
  input logic              valid_i,
  input logic [REG_AW-1:0] dbg_addr_i,
  input logic [XLEN-1:0]   dbg_data_o,
  input logic              illegal_o,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr
);
  always_comb begin
    if (rst_ni && dbg_addr_i == '0)
      AST_ZERO_READS_ZERO: assert (dbg_data_o == '0); // R9
  end

  AST_NO_WRITE_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> wr_addr != '0); // R9

  AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> valid_i); // R10

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> (dbg_addr_i != $past(dbg_addr_i) || dbg_data_o == $past(dbg_data_o))); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (dbg_addr_i != $past(dbg_addr_i) || dbg_data_o == $past(dbg_data_o))); // R11

  AST_UPPER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:26] == OPC_LUI && instr_i[20:16] != '0)
    |=> (dbg_addr_i != $past(instr_i[20:16])
         || dbg_data_o == {$past(instr_i[15:0]), 16'h0000})); // R8
endmodule

bind risc_exec_unit risc_exec_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_i    (instr_i),
  .valid_i    (valid_i),
  .dbg_addr_i (dbg_addr_i),
  .dbg_data_o (dbg_data_o),
  .illegal_o  (illegal_o),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr)
);

// File: tb/sim_risc_exec_unit.sv
`timescale 1ns/1ps
module sim_risc_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        valid = 1'b0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        illegal;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  risc_exec_unit u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .instr_i    (instr),
    .valid_i    (valid),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data),
    .illegal_o  (illegal)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [4:0]  rd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{enc_i(6'd8,  5'd0, 5'd1, 16'h0005), 5'd1,  32'h0000_0005, 8'd5},  // R5
    '{enc_i(6'd8,  5'd0, 5'd2, 16'hFFFD), 5'd2,  32'hFFFF_FFFD, 8'd5},  // R5 sign-ext
    '{enc_r(5'd1,  5'd2, 5'd3, 6'd32),    5'd3,  32'h0000_0002, 8'd2},  // R2
    '{enc_r(5'd2,  5'd1, 5'd4, 6'd34),    5'd4,  32'hFFFF_FFF8, 8'd3},  // R3
    '{enc_r(5'd2,  5'd1, 5'd5, 6'd42),    5'd5,  32'h0000_0001, 8'd4},  // R4 signed
    '{enc_r(5'd1,  5'd2, 5'd6, 6'd42),    5'd6,  32'h0000_0000, 8'd4},  // R4
    '{enc_i(6'd10, 5'd2, 5'd7, 16'h0000), 5'd7,  32'h0000_0001, 8'd6},  // R6
    '{enc_i(6'd10, 5'd1, 5'd8, 16'hFFFF), 5'd8,  32'h0000_0000, 8'd6},  // R6
    '{enc_i(6'd15, 5'd0, 5'd9, 16'hABCD), 5'd9,  32'hABCD_0000, 8'd8},  // R8
    '{enc_i(6'd13, 5'd9, 5'd9, 16'h1234), 5'd9,  32'hABCD_1234, 8'd8},  // R8 + ori
    '{enc_i(6'd12, 5'd9, 5'd10,16'hFF00), 5'd10, 32'h0000_1200, 8'd7},  // R7 andi
    '{enc_i(6'd12, 5'd2, 5'd11,16'h8001), 5'd11, 32'h0000_8001, 8'd7},  // R7 zero-ext
    '{enc_i(6'd13, 5'd1, 5'd16,16'h8000), 5'd16, 32'h0000_8005, 8'd7},  // R7 ori zero-ext
    '{enc_i(6'd15, 5'd0, 5'd12,16'h7FFF), 5'd12, 32'h7FFF_0000, 8'd8},  // R8
    '{enc_r(5'd12, 5'd12,5'd13, 6'd32),   5'd13, 32'hFFFE_0000, 8'd2},  // R2 wrap
    '{enc_r(5'd0,  5'd1, 5'd14, 6'd34),   5'd14, 32'hFFFF_FFFB, 8'd3},  // R3
    '{enc_r(5'd12, 5'd2, 5'd15, 6'd42),   5'd15, 32'h0000_0000, 8'd4},  // R4 mixed sign
    '{enc_i(6'd8,  5'd1, 5'd0, 16'h0007), 5'd0,  32'h0000_0000, 8'd9}   // R9
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic v);
    @(negedge clk);
    instr = w;
    valid = v;
    @(negedge clk);
    valid = 1'b0;
    instr = '0;
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [31:0] d);
    dbg_addr = a;
    #0.5;
    d = dbg_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    logic [31:0] d;
    logic        any_nz;
    // R1: all registers zero under reset
    any_nz = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      read_reg(i[4:0], d);
      if (d != 0) any_nz = 1'b1;
    end
    check(!any_nz, "R1 regs zero in reset", {31'd0, any_nz}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_reg(5'd17, d);
    check(d == 0, "R1 reg zero after release", d, 32'd0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      run(VECS[k].ins, 1'b1);
      read_reg(VECS[k].rd, d);
      check(d == VECS[k].exp, $sformatf("R%0d vector %0d", VECS[k].req, k), d, VECS[k].exp);
    end

    // R9: register-form write aimed at register 0
    run(enc_r(5'd1, 5'd1, 5'd0, 6'd32), 1'b1);
    read_reg(5'd0, d);
    check(d == 0, "R9 add to r0 discarded", d, 32'd0);

    // R10: illegal opcode flagged, no write
    @(negedge clk);
    instr = enc_i(6'd35, 5'd0, 5'd1, 16'h0042);
    valid = 1'b1;
    #0.5;
    check(illegal == 1'b1, "R10 bad opcode flag", {31'd0, illegal}, 32'd1);
    @(negedge clk);
    valid = 1'b0;
    #0.5;
    check(illegal == 1'b0, "R10 flag low when idle", {31'd0, illegal}, 32'd0);
    read_reg(5'd1, d);
    check(d == 32'h5, "R10 bad opcode no write", d, 32'h5);

    // R10: op 0 with unknown function code
    @(negedge clk);
    instr = enc_r(5'd1, 5'd1, 5'd3, 6'd0);
    valid = 1'b1;
    #0.5;
    check(illegal == 1'b1, "R10 bad funct flag", {31'd0, illegal}, 32'd1);
    @(negedge clk);
    valid = 1'b0;
    read_reg(5'd3, d);
    check(d == 32'h2, "R10 bad funct no write", d, 32'h2);

    // R10: legal word does not raise the flag
    @(negedge clk);
    instr = enc_i(6'd8, 5'd0, 5'd20, 16'h0001);
    valid = 1'b1;
    #0.5;
    check(illegal == 1'b0, "R10 legal word no flag", {31'd0, illegal}, 32'd0);
    @(negedge clk);
    valid = 1'b0;

    // R11: instruction present but not valid
    run(enc_i(6'd8, 5'd0, 5'd1, 16'h0077), 1'b0);
    read_reg(5'd1, d);
    check(d == 32'h5, "R11 invalid word ignored", d, 32'h5);

    // R12: debug read follows address without a clock
    @(negedge clk);
    dbg_addr = 5'd9;
    #0.5;
    check(dbg_data == 32'hABCD_1234, "R12 comb read a", dbg_data, 32'hABCD_1234);
    dbg_addr = 5'd4;
    #0.5;
    check(dbg_data == 32'hFFFF_FFF8, "R12 comb read b", dbg_data, 32'hFFFF_FFF8);

    // R1: reset mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    read_reg(5'd9, d);
    check(d == 0, "R1 async reset clears", d, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    read_reg(5'd1, d);
    check(d == 0, "R1 cleared after re-release", d, 32'd0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule